// File: doc/BRIEF.md
# Serial Port Transmit/Receive FIFO Pair with Status Word

This block sits between a host bus and a serial shift engine. It buffers outgoing words in a transmit queue and incoming words in a receive queue. Each queue is 64 entries deep and 32 bits wide by default. The host writes words into the transmit queue and reads words out of the receive queue. The engine drains the transmit queue and fills the receive queue.

Both queues are show-ahead: the oldest word is always visible at the read side. A pop in a cycle consumes that word at the next clock edge.

A register port gives the host two read/write words, chosen by `reg_sel`:
- With `reg_sel` = 0, the word is the FIFO status. It carries the empty and full flags, the occupancy counts, four sticky error flags with a summary bit, and two self-clearing flush controls.
- With `reg_sel` = 1, the word is the transfer status. It carries a sticky ready flag that the engine sets when it completes a transfer.

Software clears the sticky flags by writing 1 to them.

Top module: `spi_fifo_pair`

## Requirements
- R1: Each queue delivers words in the order they were pushed. The oldest word appears combinationally on `eng_tx_data` (transmit queue) and on `host_rd_data` (receive queue). A push and a pop in the same cycle on a queue that is neither empty nor full leave its count unchanged.
- R2: In the FIFO status word (`reg_sel` = 0), the flag bits are: bit 0 receive empty, bit 1 receive full, bit 2 transmit empty, bit 3 transmit full.
- R3: Bits 22:16 of the FIFO status word hold the number of free transmit entries, which reads 64 when the transmit queue is empty. Bits 29:23 hold the number of filled receive entries.
- R4: A push into a full queue is dropped. A pop from an empty queue leaves the queue unchanged and sets an underflow flag; the receive side returns zero on `host_rd_data`. The push case sets an overflow flag. The flags are: bit 4 receive underflow, bit 5 receive overflow, bit 6 transmit underflow, bit 7 transmit overflow.
- R5: Bits 7:4 are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A new error event in the same cycle as a clear leaves the bit set. Bit 8 is the OR of bits 7:4.
- R6: Writing 1 to bit 14 of the FIFO status word requests a transmit flush, and writing 1 to bit 15 requests a receive flush. The written bit reads 1 in the following cycle. At the end of that cycle the queue is emptied and the bit returns to 0. Pushes during that cycle are lost.
- R7: In the transfer status word (`reg_sel` = 1), bit 30 is a ready flag. A pulse on `xfer_done` sets it and writing 1 to it clears it; a set wins over a same-cycle clear. All other bits of that word read 0.
- R8: After reset both queues are empty, all flags and flush bits are clear, and the FIFO status word reads 0x0040_0005.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_tx_wr | input | 1 | Host push into transmit queue |
| host_wr_data | input | 32 | Word pushed by host |
| host_rx_rd | input | 1 | Host pop from receive queue |
| host_rd_data | output | 32 | Oldest receive word, zero when empty |
| eng_tx_rd | input | 1 | Engine pop from transmit queue |
| eng_tx_data | output | 32 | Oldest transmit word, zero when empty |
| eng_rx_wr | input | 1 | Engine push into receive queue |
| eng_rx_data | input | 32 | Word pushed by engine |
| xfer_done | input | 1 | Engine completion pulse, sets ready flag |
| reg_sel | input | 1 | 0 selects FIFO status word, 1 selects transfer status word |
| reg_wr_en | input | 1 | Write strobe for the selected word |
| reg_wr_data | input | 32 | Write data: 1 bits clear flags or request flushes |
| reg_rd_data | output | 32 | Contents of the selected word |

## Verification
The collision that matters is a write-1-to-clear landing in the same cycle as a fresh error or completion event. Directed steps push into a full transmit queue and pop an empty one while the matching clear bits are written; they also pulse `xfer_done` while the ready flag is cleared. A flag that survives shows that the set took priority.

A second collision is a flush that coincides with a push. The bench drives a push in the flush cycle and expects the queue to read empty afterwards. A cycle-accurate queue model in the bench judges every status field, both data outputs and the transfer word in each cycle, across long random runs with mixed push, pop, clear and flush traffic.

// File: rtl/spi_fq_pkg.sv
package spi_fq_pkg;

    localparam int FQ_WIDTH    = 32;
    localparam int FQ_CNT_BITS = 7;

    // Sticky error index; order matches the status word bits 7:4
    typedef enum logic [1:0] {
        ERR_RX_UNF = 2'd0,
        ERR_RX_OVF = 2'd1,
        ERR_TX_UNF = 2'd2,
        ERR_TX_OVF = 2'd3
    } fq_err_e;

    typedef struct packed {
        logic                   empty;
        logic                   full;
        logic [FQ_CNT_BITS-1:0] cnt;
    } fq_state_t;

    localparam int BIT_TX_FLUSH = 14;
    localparam int BIT_RX_FLUSH = 15;
    localparam int BIT_READY    = 30;

    function automatic logic [31:0] fq_status_word(
        input fq_state_t              tx,
        input fq_state_t              rx,
        input logic [FQ_CNT_BITS-1:0] tx_free,
        input logic [3:0]             err,
        input logic                   fl_tx,
        input logic                   fl_rx
    );
        logic [31:0] w;
        w          = '0;
        w[0]       = rx.empty;
        w[1]       = rx.full;
        w[2]       = tx.empty;
        w[3]       = tx.full;
        w[7:4]     = err;
        w[8]       = |err;
        w[BIT_TX_FLUSH] = fl_tx;
        w[BIT_RX_FLUSH] = fl_rx;
        w[22:16]   = tx_free;
        w[29:23]   = rx.cnt;
        return w;
    endfunction

endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_evt,
    output logic             unf_evt
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             empty, full, do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == FULL_CNT);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign ovf_evt = push && full;
    assign unf_evt = pop && empty;
    assign head    = empty ? '0 : mem[rd_ptr];
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/sfq_sticky.sv
module sfq_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)          q[i] <= 1'b0;
            else if (set[i])  q[i] <= 1'b1;
            else if (clr[i])  q[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
    import spi_fq_pkg::*;
#(
    parameter int WIDTH = FQ_WIDTH,
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_tx_wr,
    input  logic [WIDTH-1:0] host_wr_data,
    input  logic             host_rx_rd,
    output logic [WIDTH-1:0] host_rd_data,
    input  logic             eng_tx_rd,
    output logic [WIDTH-1:0] eng_tx_data,
    input  logic             eng_rx_wr,
    input  logic [WIDTH-1:0] eng_rx_data,
    input  logic             xfer_done,
    input  logic             reg_sel,
    input  logic             reg_wr_en,
    input  logic [31:0]      reg_wr_data,
    output logic [31:0]      reg_rd_data
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             tx_ovf, tx_unf, rx_ovf, rx_unf;
    logic [1:0]       flush_q;          // [0] transmit, [1] receive
    logic [3:0]       err_q, err_set, err_clr;
    logic             ready_q;
    logic             wr_fifo_word, wr_xfer_word;
    fq_state_t        tx_st, rx_st;

    assign wr_fifo_word = reg_wr_en && !reg_sel;
    assign wr_xfer_word = reg_wr_en && reg_sel;

    sfq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst(rst), .flush(flush_q[0]),
        .push(host_tx_wr), .push_data(host_wr_data),
        .pop(eng_tx_rd), .head(eng_tx_data), .cnt(tx_cnt),
        .ovf_evt(tx_ovf), .unf_evt(tx_unf)
    );

    sfq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rx (
        .clk(clk), .rst(rst), .flush(flush_q[1]),
        .push(eng_rx_wr), .push_data(eng_rx_data),
        .pop(host_rx_rd), .head(host_rd_data), .cnt(rx_cnt),
        .ovf_evt(rx_ovf), .unf_evt(rx_unf)
    );

    always_comb begin
        err_set             = '0;
        err_set[ERR_RX_UNF] = rx_unf;
        err_set[ERR_RX_OVF] = rx_ovf;
        err_set[ERR_TX_UNF] = tx_unf;
        err_set[ERR_TX_OVF] = tx_ovf;
        err_clr             = wr_fifo_word ? reg_wr_data[7:4] : 4'b0;
    end

    sfq_sticky #(.N(4)) u_err (
        .clk(clk), .rst(rst), .set(err_set), .clr(err_clr), .q(err_q)
    );

    sfq_sticky #(.N(1)) u_rdy (
        .clk(clk), .rst(rst), .set(xfer_done),
        .clr(wr_xfer_word && reg_wr_data[BIT_READY]), .q(ready_q)
    );

    always_ff @(posedge clk) begin
        if (rst) flush_q <= '0;
        else     flush_q <= wr_fifo_word ? reg_wr_data[BIT_RX_FLUSH:BIT_TX_FLUSH] : 2'b00;
    end

    always_comb begin
        tx_st.cnt   = FQ_CNT_BITS'(tx_cnt);
        tx_st.empty = (tx_cnt == '0);
        tx_st.full  = (tx_cnt == FULL_CNT);
        rx_st.cnt   = FQ_CNT_BITS'(rx_cnt);
        rx_st.empty = (rx_cnt == '0);
        rx_st.full  = (rx_cnt == FULL_CNT);
    end

    always_comb begin
        if (reg_sel) begin
            reg_rd_data            = '0;
            reg_rd_data[BIT_READY] = ready_q;
        end else begin
            reg_rd_data = fq_status_word(tx_st, rx_st,
                                         FQ_CNT_BITS'(FULL_CNT - tx_cnt),
                                         err_q, flush_q[0], flush_q[1]);
        end
    end

endmodule

// File: rtl/spi_fifo_pair_chk.sv
module spi_fifo_pair_chk #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             host_tx_wr,
    input logic             eng_tx_rd,
    input logic             host_rx_rd,
    input logic [WIDTH-1:0] host_rd_data,
    input logic             reg_sel,
    input logic             reg_wr_en,
    input logic [31:0]      reg_wr_data,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] rx_cnt,
    input logic [3:0]       err_q,
    input logic [1:0]       flush_q
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    p_push_pop_r1: assert property (@(posedge clk) disable iff (rst)
        host_tx_wr && eng_tx_rd && tx_cnt != '0 && tx_cnt != FULL_CNT && !flush_q[0]
        |=> $stable(tx_cnt));

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        tx_cnt <= FULL_CNT && rx_cnt <= FULL_CNT);

    p_full_drop_r4: assert property (@(posedge clk) disable iff (rst)
        host_tx_wr && !eng_tx_rd && tx_cnt == FULL_CNT && !flush_q[0]
        |=> tx_cnt == FULL_CNT);

    p_ovf_set_r4: assert property (@(posedge clk) disable iff (rst)
        host_tx_wr && tx_cnt == FULL_CNT |=> err_q[3]);

    p_unf_zero_r4: assert property (@(posedge clk) disable iff (rst)
        host_rx_rd && rx_cnt == '0 |-> host_rd_data == '0);

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        err_q[3] && !(reg_wr_en && !reg_sel && reg_wr_data[7]) |=> err_q[3]);

    p_flush_empties_r6: assert property (@(posedge clk) disable iff (rst)
        flush_q[0] |=> tx_cnt == '0);

    p_flush_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        flush_q[0] && !(reg_wr_en && !reg_sel && reg_wr_data[14]) |=> !flush_q[0]);

endmodule

bind spi_fifo_pair spi_fifo_pair_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .host_tx_wr(host_tx_wr), .eng_tx_rd(eng_tx_rd),
    .host_rx_rd(host_rx_rd), .host_rd_data(host_rd_data),
    .reg_sel(reg_sel), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .err_q(err_q), .flush_q(flush_q)
);

// File: tb/spi_fifo_pair_tb_top.sv
module spi_fifo_pair_tb_top;

    localparam int D = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_tx_wr, host_rx_rd, eng_tx_rd, eng_rx_wr, xfer_done;
    logic        reg_sel, reg_wr_en;
    logic [31:0] host_wr_data, eng_rx_data, reg_wr_data;
    logic [31:0] host_rd_data, eng_tx_data, reg_rd_data;

    int checks = 0;
    int errors = 0;

    logic [31:0] q_tx[$];
    logic [31:0] q_rx[$];
    logic [3:0]  m_err = '0;
    logic        m_rdy = 1'b0;
    logic        m_ftx = 1'b0;
    logic        m_frx = 1'b0;

    always #5 clk = ~clk;

    spi_fifo_pair dut_i (
        .clk(clk), .rst(rst),
        .host_tx_wr(host_tx_wr), .host_wr_data(host_wr_data),
        .host_rx_rd(host_rx_rd), .host_rd_data(host_rd_data),
        .eng_tx_rd(eng_tx_rd), .eng_tx_data(eng_tx_data),
        .eng_rx_wr(eng_rx_wr), .eng_rx_data(eng_rx_data),
        .xfer_done(xfer_done), .reg_sel(reg_sel), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_status();
        int txn = q_tx.size();
        int rxn = q_rx.size();
        logic [31:0] w = '0;
        w[0] = (rxn == 0);
        w[1] = (rxn == D);
        w[2] = (txn == 0);
        w[3] = (txn == D);
        w[7:4] = m_err;
        w[8] = |m_err;
        w[14] = m_ftx;
        w[15] = m_frx;
        w[22:16] = 7'(D - txn);
        w[29:23] = 7'(rxn);
        return w;
    endfunction

    task automatic compare();
        logic [31:0] s, e;
        reg_sel = 1'b0;
        #1;
        s = reg_rd_data;
        e = exp_status();
        chk("R2 empty/full flags", {28'b0, s[3:0]}, {28'b0, e[3:0]});
        chk("R3 occupancy counts", {2'b0, s[29:16], 16'b0}, {2'b0, e[29:16], 16'b0});
        chk("R4/R5 sticky errors", {23'b0, s[8:4], 4'b0}, {23'b0, e[8:4], 4'b0});
        chk("R6 flush bits", {16'b0, s[15:14], 14'b0}, {16'b0, e[15:14], 14'b0});
        chk("R1 tx head", eng_tx_data, (q_tx.size() != 0) ? q_tx[0] : 32'h0);
        chk("R1/R4 rx head", host_rd_data, (q_rx.size() != 0) ? q_rx[0] : 32'h0);
        reg_sel = 1'b1;
        #1;
        chk("R7 transfer word", reg_rd_data, {1'b0, m_rdy, 30'b0});
    endtask

    task automatic cycle(input logic hw, input logic [31:0] hwd, input logic hr,
                         input logic ep, input logic er, input logic [31:0] erd,
                         input logic we, input logic sel, input logic [31:0] wd,
                         input logic dn);
        int txn, rxn;
        logic [3:0] set, clr;
        @(negedge clk);
        compare();
        host_tx_wr = hw; host_wr_data = hwd; host_rx_rd = hr;
        eng_tx_rd = ep; eng_rx_wr = er; eng_rx_data = erd;
        reg_wr_en = we; reg_sel = sel; reg_wr_data = wd; xfer_done = dn;
        txn = q_tx.size();
        rxn = q_rx.size();
        set = {hw && txn == D, ep && txn == 0, er && rxn == D, hr && rxn == 0};
        clr = (we && !sel) ? wd[7:4] : 4'b0;
        m_err = (m_err & ~clr) | set;
        if (m_ftx) q_tx.delete();
        else begin
            if (ep && txn > 0) void'(q_tx.pop_front());
            if (hw && txn < D) q_tx.push_back(hwd);
        end
        if (m_frx) q_rx.delete();
        else begin
            if (hr && rxn > 0) void'(q_rx.pop_front());
            if (er && rxn < D) q_rx.push_back(erd);
        end
        m_ftx = we && !sel && wd[14];
        m_frx = we && !sel && wd[15];
        m_rdy = (m_rdy && !(we && sel && wd[30])) || dn;
        @(posedge clk);
    endtask

    task automatic idle();
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1;
        host_tx_wr = 0; host_rx_rd = 0; eng_tx_rd = 0; eng_rx_wr = 0; xfer_done = 0;
        reg_sel = 0; reg_wr_en = 0; host_wr_data = 0; eng_rx_data = 0; reg_wr_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        reg_sel = 1'b0;
        #1;
        chk("R8 reset status word", reg_rd_data, 32'h0040_0005);

        // R1 R2 R3: fill transmit queue to full, then one extra push (R4 overflow)
        for (int i = 0; i < D + 1; i++) cycle(1, 32'hA000_0000 + i, 0, 0, 0, 0, 0, 0, 0, 0);
        idle();
        // R5: writing zero leaves the flag, then clear collides with a new overflow
        cycle(0, 0, 0, 0, 0, 0, 1, 0, 32'h0, 0);
        cycle(1, 32'hDEAD, 0, 0, 0, 0, 1, 0, 32'h80, 0);
        cycle(0, 0, 0, 0, 0, 0, 1, 0, 32'h80, 0);
        // R1: drain with one simultaneous push/pop, then R4 underflow on both sides
        cycle(1, 32'hB0B0, 0, 1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < D + 1; i++) cycle(0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        idle();
        cycle(0, 0, 0, 0, 0, 0, 1, 0, 32'hF0, 0);
        // R6: fill both, flush with a push landing in the flush cycle
        for (int i = 0; i < 10; i++) cycle(1, 32'hC0 + i, 0, 0, 1, 32'hE0 + i, 0, 0, 0, 0);
        cycle(0, 0, 0, 0, 0, 0, 1, 0, 32'h0000_C000, 0);
        cycle(1, 32'h1234, 0, 0, 1, 32'h5678, 0, 0, 0, 0);
        idle();
        // R7: ready set, write 0, clear, then set and clear together
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        cycle(0, 0, 0, 0, 0, 0, 1, 1, 32'h0, 0);
        cycle(0, 0, 0, 0, 0, 0, 1, 1, 32'h4000_0000, 0);
        cycle(0, 0, 0, 0, 0, 0, 1, 1, 32'h4000_0000, 1);
        cycle(0, 0, 0, 0, 0, 0, 1, 1, 32'h4000_0000, 0);
        idle();

        // Random phase: fill/drain bias changes every 150 cycles
        for (int n = 0; n < 3000; n++) begin
            int bias = (n / 150) % 3;
            int r = $urandom_range(0, 99);
            logic hw = ($urandom_range(0, 99) < (bias == 0 ? 70 : bias == 1 ? 30 : 50));
            logic ep = ($urandom_range(0, 99) < (bias == 0 ? 30 : bias == 1 ? 70 : 50));
            logic er = ($urandom_range(0, 99) < (bias == 0 ? 70 : bias == 1 ? 30 : 50));
            logic hr = ($urandom_range(0, 99) < (bias == 0 ? 30 : bias == 1 ? 70 : 50));
            logic we = (r < 6);
            logic sel = $urandom_range(0, 1) != 0;
            logic [31:0] wd = $urandom();
            if (r < 5) wd[15:14] = 2'b00;
            cycle(hw, $urandom(), hr, ep, er, $urandom(), we, sel, wd, $urandom_range(0, 49) == 0);
        end
        @(negedge clk);
        compare();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule